// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller with Byte-Lane Writes

This block is the clocked control path of a single-port burst SRAM, with a small storage array. Every rising clock edge samples two address strobes, three chip enables, a burst-advance input and the write controls. A strobe either loads a new external address or deselects the device. While a burst is selected, the advance input steps a two-bit counter on the low address bits. In every selected cycle the block reads or writes one 72-bit word.

The word is split into eight byte lanes of nine bits each: eight data bits and one parity bit. A global write stores the whole word. A byte write stores only the lanes the caller picks. When a selected cycle qualifies no write, the block reads, and the word is presented on the output one clock later with a valid flag.

Top module: `sbf_burst_sram`

## Requirements
- R1: All inputs are sampled on the rising clock edge. During and right after reset `rd_valid` is 0 and `rdata` is 0, and the device is deselected.
- R2: An address is loaded when `adsc_n` is 0, or when `adsp_n` is 0 with `ce1_n` at 0, provided `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A read of that address shows on `rdata` with `rd_valid`=1 after that same edge.
- R3: While `ce1_n` is 1, a low `adsp_n` (with `adsc_n` high) is ignored: it neither loads nor deselects, and a running burst goes on as if the strobe were high.
- R4: A strobe that is accepted while any chip enable is inactive deselects the device. Until the next load, no cycle reads (`rd_valid`=0) or writes, whatever `adv_n`, `gw_n`, `bwe_n` and `bw_n` do.
- R5: The chip enables are only looked at on a strobe cycle. Changing them during a burst has no effect on the burst.
- R6: On a load, `addr[1:0]` enters the burst counter. Each non-strobe selected cycle with `adv_n`=0 adds one to the counter, wrapping modulo 4, and `addr[5:2]` stays fixed for the whole burst.
- R7: A selected non-strobe cycle with `adv_n`=1 accesses the same word again.
- R8: With `gw_n`=0, a selected cycle writes all nine bits of all eight lanes, whatever `bwe_n` and `bw_n` are.
- R9: With `gw_n`=1, lane i is written only when `bwe_n`=0 and `bw_n[i]`=0. The other lanes keep their old contents.
- R10: With `gw_n`=1 and either `bwe_n`=1 or `bw_n` all ones, the selected cycle is a read.
- R11: After a write cycle, `rd_valid` is 0 for the next cycle.
- R12: Lane i occupies bits [9i+8:9i] of `wdata` and `rdata`, with bit 9i+8 as its parity bit. A lane write stores the parity bit along with the data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples all inputs |
| rst_n | input | 1 | Active-low reset |
| addr | input | 6 | External word address |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by ce1_n |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 8 | Per-lane byte selects, active low |
| wdata | input | 72 | Write word, eight 9-bit lanes |
| rdata | output | 72 | Read word, registered |
| rd_valid | output | 1 | rdata holds a read from the previous cycle |

## Verification
The bench goes after a burst that starts at counter value 2 and wraps through 3 and 0. A counter that carried into the upper address bits, or that stopped at 3, would return the wrong word there. It strobes `adsp_n` with `ce1_n` high in the middle of a burst: a design that did not gate that strobe would jump to a stray address or drop the burst. It also flips the chip enables while advancing, so a design that re-sampled them would deselect itself. After a deselect it sends advance and global-write pulses. A design that kept the old burst alive would show reads, and would corrupt a word that the bench reads back later. It tries byte writes with scattered lane selects, parity-only patterns, and byte-enable with no lanes selected, so that a swapped lane, a lost parity bit or a spurious write shows up in read-back data.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
   // width of the wrapping burst counter on the low address bits
   parameter int SBF_BURST_W = 2;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;
endpackage

// File: rtl/sbf_addr_ctl.sv
module sbf_addr_ctl #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              adv_n,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   output logic              access,
   output logic [ADDR_W-1:0] eff_addr
);
   localparam int UP_W = ADDR_W - BURST_W;

   initial begin
      assert (ADDR_W > BURST_W) else $error("address must be wider than burst counter");
      assert (BURST_W >= 1) else $error("burst counter needs at least one bit");
   end

   logic               sel_q;
   logic [UP_W-1:0]    up_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_nxt;
   logic               strobe;
   logic               enabled;
   logic               step;

   always_comb begin
      // the processor strobe only counts while the first enable is active
      strobe  = (!adsp_n && !ce1_n) || !adsc_n;
      enabled = !ce1_n && ce2 && !ce3_n;
      step    = !strobe && sel_q && !adv_n;
      cnt_nxt = step ? BURST_W'(cnt_q + 1'b1) : cnt_q;
      access  = strobe ? enabled : sel_q;
      eff_addr = strobe ? addr : {up_q, cnt_nxt};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         up_q  <= '0;
         cnt_q <= '0;
      end else if (strobe) begin
         sel_q <= enabled;
         if (enabled) begin
            {up_q, cnt_q} <= addr;
         end else begin
            up_q  <= '0;
            cnt_q <= '0;
         end
      end else if (step) begin
         cnt_q <= cnt_nxt;
      end
   end

   // R6: the counter takes the low address bits on a selecting strobe
   assert_load_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && enabled) |=> (cnt_q == $past(addr[BURST_W-1:0])));

   // R6: an advance steps the counter by one, wrapping
   assert_adv_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && sel_q && !adv_n) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

   // R6: the upper bits do not move without a strobe
   assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(up_q));

   // R7: no advance, no strobe -> counter holds
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && adv_n) |=> $stable(cnt_q));

   // R4: a strobe with enables inactive deselects
   assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !enabled) |=> !sel_q);

   // R3: a gated processor strobe leaves the selection alone
   assert_gated_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce1_n && adsc_n) |=> (sel_q == $past(sel_q)));
endmodule

// File: rtl/sbf_wr_dec.sv
module sbf_wr_dec #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             access,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we,
   output logic             wr_any
);
   initial begin
      assert (LANES >= 1) else $error("need at least one byte lane");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // global write wins over the per-lane selects
      assign lane_we[i] = access && (!gw_n || (!bwe_n && !bw_n[i]));
   end

   assign wr_any = |lane_we;

   // R8: global write drives every lane
   assert_global_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !gw_n) |-> (&lane_we));

   // R9: a lane whose select is high stays untouched in a byte write
   assert_lane_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gw_n |-> ((lane_we & bw_n) == '0));

   // R4: nothing is written without an access
   assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !access |-> (lane_we == '0));
endmodule

// File: rtl/sbf_lane_mem.sv
module sbf_lane_mem #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] rd
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (ADDR_W <= 10) else $error("lane array too deep");
   end

   logic [LANE_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[addr] <= wd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd <= '0;
      end else if (re) begin
         rd <= mem_q[addr];
      end
   end

   // R11: read and write never share a cycle in one lane
   assert_rw_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && re));
endmodule

// File: rtl/sbf_burst_sram.sv
module sbf_burst_sram
   import sbf_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int DATA_W = 8,
   parameter int PAR_W  = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               addr,
   input  logic                            adsp_n,
   input  logic                            adsc_n,
   input  logic                            adv_n,
   input  logic                            ce1_n,
   input  logic                            ce2,
   input  logic                            ce3_n,
   input  logic                            gw_n,
   input  logic                            bwe_n,
   input  logic [LANES-1:0]                bw_n,
   input  logic [LANES*(DATA_W+PAR_W)-1:0] wdata,
   output logic [LANES*(DATA_W+PAR_W)-1:0] rdata,
   output logic                            rd_valid
);
   localparam int LANE_W = DATA_W + PAR_W;

   initial begin
      assert (DATA_W >= 1 && PAR_W >= 0) else $error("bad lane geometry");
   end

   logic              access;
   logic [ADDR_W-1:0] eff_addr;
   logic [LANES-1:0]  lane_we;
   logic              wr_any;
   cyc_e              cyc;

   sbf_addr_ctl #(.ADDR_W(ADDR_W), .BURST_W(SBF_BURST_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
      .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .access(access), .eff_addr(eff_addr)
   );

   sbf_wr_dec #(.LANES(LANES)) u_wdec (
      .clk(clk), .rst_n(rst_n), .access(access),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
      .lane_we(lane_we), .wr_any(wr_any)
   );

   always_comb begin
      if (!access)     cyc = CYC_IDLE;
      else if (wr_any) cyc = CYC_WRITE;
      else             cyc = CYC_READ;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sbf_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
         .clk(clk), .rst_n(rst_n), .addr(eff_addr),
         .we(lane_we[i]), .re(cyc == CYC_READ),
         .wd(wdata[i*LANE_W +: LANE_W]),
         .rd(rdata[i*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= (cyc == CYC_READ);
   end

   // R11: a write cycle is followed by no valid read
   assert_write_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (access && wr_any) |=> !rd_valid);

   // R10: qualified access without lane strobes reads
   assert_read_when_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (access && (lane_we == '0)) |=> rd_valid);

   // R4: idle cycles produce no valid read
   assert_idle_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !access |=> !rd_valid);
endmodule

// File: tb/sbf_burst_sram_tb.sv
module sbf_burst_sram_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr;
   logic        adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
   logic [7:0]  bw_n;
   logic [71:0] wdata;
   logic [71:0] rdata;
   logic        rd_valid;

   int checks = 0;
   int errors = 0;

   logic [71:0] mem_m [64];
   logic        m_sel;
   logic [3:0]  m_up;
   logic [1:0]  m_cnt;

   always #2.5 clk = ~clk;

   sbf_burst_sram u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
      .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
   );

   function automatic logic [71:0] rand72();
      return {8'($urandom), $urandom, $urandom};
   endfunction

   // one clock: drive, predict, then compare at the following falling edge
   task automatic step(input string tag, input logic [5:0] a,
                       input logic p_n, input logic c_n, input logic v_n,
                       input logic e1_n, input logic e2, input logic e3_n,
                       input logic g_n, input logic be_n, input logic [7:0] b_n,
                       input logic [71:0] wd);
      logic       strobe, en, acc, wr;
      logic [5:0] ea;
      logic [1:0] cn;
      logic       exp_v;
      logic [71:0] exp_d;
      addr = a; adsp_n = p_n; adsc_n = c_n; adv_n = v_n;
      ce1_n = e1_n; ce2 = e2; ce3_n = e3_n; gw_n = g_n; bwe_n = be_n;
      bw_n = b_n; wdata = wd;
      strobe = (!p_n && !e1_n) || !c_n;
      en     = !e1_n && e2 && !e3_n;
      cn     = (!strobe && m_sel && !v_n) ? m_cnt + 2'd1 : m_cnt;
      acc    = strobe ? en : m_sel;
      ea     = strobe ? a : {m_up, cn};
      wr     = !g_n || (!be_n && (b_n != 8'hFF));
      exp_v  = acc && !wr;
      exp_d  = exp_v ? mem_m[ea] : 72'h0;
      if (acc && wr) begin
         for (int i = 0; i < 8; i++) begin
            if (!g_n || (!be_n && !b_n[i])) mem_m[ea][i*9 +: 9] = wd[i*9 +: 9];
         end
      end
      if (strobe) begin
         m_sel = en;
         {m_up, m_cnt} = en ? a : 6'd0;
      end else begin
         m_cnt = cn;
      end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (rd_valid !== exp_v || (exp_v && rdata !== exp_d)) begin
         errors++;
         $display("FAIL %s: rd_valid=%0b rdata=%h expected rd_valid=%0b rdata=%h",
                  tag, rd_valid, rdata, exp_v, exp_d);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_sel = 1'b0; m_up = '0; m_cnt = '0;
      addr = '0; adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 1; ce2 = 0; ce3_n = 1;
      gw_n = 1; bwe_n = 1; bw_n = 8'hFF; wdata = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      checks++;
      if (rd_valid !== 1'b0 || rdata !== 72'h0) begin
         errors++;
         $display("FAIL R1: rd_valid=%0b rdata=%h expected 0 and 0", rd_valid, rdata);
      end
      // R1: idle strobes high, deselected -> no read
      step("R1", 6'h0A, 1, 1, 0, 0, 1, 0, 1, 1, 8'hFF, '0);

      // R8 / R11: fill every word with a global write (bwe/bw inactive)
      for (int a = 0; a < 64; a++) begin
         step("R8", 6'(a), 1, 0, 1, 0, 1, 0, 0, 1, 8'hFF, rand72());
      end
      // R8: global write overriding a byte pattern
      step("R8", 6'h09, 1, 0, 1, 0, 1, 0, 0, 0, 8'hFE, rand72());
      step("R8", 6'h09, 1, 0, 1, 0, 1, 0, 1, 1, 8'hFF, '0);

      // R2 / R6: load at counter value 2 via adsp, advance and wrap
      step("R2", 6'h22, 0, 1, 1, 0, 1, 0, 1, 1, 8'hFF, '0);
      step("R6", 6'h00, 1, 1, 0, 0, 1, 0, 1, 1, 8'hFF, '0);
      // R3: gated processor strobe in mid-burst, burst continues
      step("R3", 6'h3F, 0, 1, 0, 1, 1, 0, 1, 1, 8'hFF, '0);
      // R5: enables dropped while advancing, burst continues
      step("R5", 6'h15, 1, 1, 0, 0, 0, 1, 1, 1, 8'hFF, '0);
      step("R6", 6'h15, 1, 1, 0, 1, 0, 1, 1, 1, 8'hFF, '0);
      // R7: hold address without advance
      step("R7", 6'h00, 1, 1, 1, 0, 1, 0, 1, 1, 8'hFF, '0);

      // R4: deselect with ce2 low, then advance and write attempts
      step("R4", 6'h22, 1, 0, 1, 0, 0, 0, 1, 1, 8'hFF, '0);
      step("R4", 6'h22, 1, 1, 0, 0, 1, 0, 1, 1, 8'hFF, '0);
      step("R4", 6'h22, 1, 1, 0, 0, 1, 0, 0, 0, 8'h00, {72{1'b1}});
      step("R4", 6'h00, 1, 0, 1, 0, 1, 1, 1, 1, 8'hFF, '0);
      step("R4", 6'h20, 1, 0, 1, 0, 1, 0, 1, 1, 8'hFF, '0);
      step("R4", 6'h00, 1, 1, 0, 0, 1, 0, 1, 1, 8'hFF, '0);

      // R9: scattered byte write, then read back by holding
      step("R9", 6'h05, 1, 0, 1, 0, 1, 0, 1, 0, 8'b1010_0101, rand72());
      step("R9", 6'h05, 1, 1, 1, 0, 1, 0, 1, 1, 8'hFF, '0);
      step("R9", 6'h05, 1, 1, 1, 0, 1, 0, 1, 0, 8'b0111_1111, rand72());
      step("R9", 6'h05, 1, 1, 1, 0, 1, 0, 1, 1, 8'hFF, '0);
      // R10: byte enable with no lanes picked is a read
      step("R10", 6'h06, 1, 0, 1, 0, 1, 0, 1, 0, 8'hFF, rand72());
      step("R10", 6'h06, 1, 1, 1, 0, 1, 0, 1, 1, 8'h00, rand72());
      // R12: parity-only pattern, then a single-lane write touching its parity bit
      begin
         logic [71:0] par;
         par = '0;
         for (int i = 0; i < 8; i++) par[i*9 + 8] = 1'b1;
         step("R12", 6'h07, 1, 0, 1, 0, 1, 0, 0, 1, 8'hFF, par);
         step("R12", 6'h07, 1, 1, 1, 0, 1, 0, 1, 1, 8'hFF, '0);
         step("R12", 6'h07, 1, 1, 1, 0, 1, 0, 1, 0, 8'b1111_1011, {72{1'b0}});
         step("R12", 6'h07, 1, 1, 1, 0, 1, 0, 1, 1, 8'hFF, '0);
      end

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic p, c, v, e1, e2, e3, g, be;
         logic [7:0] b;
         p  = ($urandom % 4) != 0;
         c  = ($urandom % 4) != 0;
         v  = ($urandom % 3) == 0;
         e1 = ($urandom % 8) == 0;
         e2 = ($urandom % 8) != 0;
         e3 = ($urandom % 8) == 0;
         g  = ($urandom % 6) != 0;
         be = ($urandom % 2) != 0;
         b  = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
         step((!g || (!be && b != 8'hFF)) ? "R11" : "R2",
              6'($urandom), p, c, v, e1, e2, e3, g, be, b, rand72());
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule